// File: doc/BRIEF.md
# Two-Key Watchdog Service Timer

This block is a free-running watchdog counter clocked by the system clock. Left alone, it reaches a terminal count and pulses a system reset request. Software keeps it quiet by writing to one byte-wide service register on the bus, in two steps. A write of 0x55 arms the clearing logic. A later write of 0xAA, made while the logic is armed, restarts the count. Any number of unrelated bus cycles may fall between the two writes. The pair must land, in that order, before the count runs out.

Four timeout lengths can be chosen with a two-bit period select. With the default parameters they are 2^15, 2^17, 2^19 and 2^21 clocks. An enable input holds the watchdog idle when it is low. The service register is write-only. Its contents have no state of their own, and only the key values have any effect.

Top module: `wdt_service_timer`

## Requirements
- R1: After reset `rst_req` is 0. With `en` high, the first timeout pulse comes on the LIMIT-th clock edge after reset is released.
- R2: LIMIT is 2^(BASE_SHIFT + SHIFT_STEP*`period_sel`), where `period_sel` is 0 to 3. Each timeout drives `rst_req` high for exactly one cycle.
- R3: A write of 0x55 to the service address (0x103A) only arms the clearing logic. It does not move the timeout.
- R4: A write of 0xAA to the service address while armed restarts the count. The next pulse comes LIMIT edges after the edge that captured the write.
- R5: Writes of other data values to the service address, and idle bus cycles, leave an existing arm intact.
- R6: A 0xAA write made while not armed is ignored, and the count keeps running.
- R7: A restart consumes the arm. A further 0xAA write without a new 0x55 is ignored.
- R8: A timeout returns both the count and the arm to zero. Pulses therefore repeat every LIMIT edges, and an arm made before a timeout cannot be used after it.
- R9: While `en` is low, the count is held at zero, no pulse is produced and the arm is cleared. Counting resumes from zero on the first edge with `en` high.
- R10: If a restart write is captured on the same edge where the count would expire, the restart wins and no pulse is produced.
- R11: Key values written to any address other than the service address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counter advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Watchdog enable; low holds the block idle |
| period_sel | input | 2 | Selects one of four timeout lengths |
| bus_we | input | 1 | Bus write strobe, sampled on the clock edge |
| bus_addr | input | 16 | Bus write address |
| bus_wdata | input | 8 | Bus write data byte |
| rst_req | output | 1 | One-cycle system reset request on timeout |

## Verification
A bus write takes effect on the edge that captures it, and nothing registers the key decode on the way. The count is zeroed on one edge: the capturing edge of a restart, the last edge of reset, the last edge with `en` low, or the edge of the previous timeout. `rst_req` then rises on the LIMIT-th edge after that edge and falls on the next one. The bench numbers every rising edge with a free counter. It drives and samples 1 ns after an edge, records the index of the edge that captured each write, and compares the index of the first sample with `rst_req` high against the index it computes from the requirement. An early pulse, a late pulse and a missing pulse all show up as a wrong index.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int unsigned BYTE_W = 8;

  // Service key values
  localparam logic [BYTE_W-1:0] KEY_ARM_VAL   = 8'h55;
  localparam logic [BYTE_W-1:0] KEY_CLEAR_VAL = 8'hAA;

  // Decoded meaning of one bus cycle
  typedef enum logic [1:0] {
    KEY_NONE      = 2'd0,
    KEY_ARM_HIT   = 2'd1,
    KEY_CLEAR_HIT = 2'd2
  } key_kind_e;

  // Timeout exponent for one select code
  function automatic int unsigned period_shift(int unsigned base,
                                               int unsigned step,
                                               int unsigned sel);
    return base + step * sel;
  endfunction
endpackage

// File: rtl/wdt_bus_decode.sv
`timescale 1ns/1ps
module wdt_bus_decode #(
  parameter int unsigned      ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = ADDR_W'(16'h103A)
) (
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [wdt_pkg::BYTE_W-1:0] bus_wdata,
  output wdt_pkg::key_kind_e         key
);
  import wdt_pkg::*;

  logic sel_hit;
  assign sel_hit = bus_we && (bus_addr == SVC_ADDR);

  always_comb begin
    key = KEY_NONE;
    if (sel_hit) begin
      if (bus_wdata == KEY_ARM_VAL)        key = KEY_ARM_HIT;
      else if (bus_wdata == KEY_CLEAR_VAL) key = KEY_CLEAR_HIT;
    end
  end
endmodule

// File: rtl/wdt_arm_ctrl.sv
`timescale 1ns/1ps
module wdt_arm_ctrl (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  wdt_pkg::key_kind_e key,
  input  logic               timeout,
  output logic               armed_q,
  output logic               restart
);
  import wdt_pkg::*;

  // A clear key counts only while the arm is held
  assign restart = en && armed_q && (key == KEY_CLEAR_HIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (!en || restart || timeout) begin
      armed_q <= 1'b0;
    end else if (key == KEY_ARM_HIT) begin
      armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_timebase.sv
`timescale 1ns/1ps
module wdt_timebase #(
  parameter int unsigned BASE_SHIFT = 15,
  parameter int unsigned SHIFT_STEP = 2,
  parameter int unsigned SEL_W      = 2,
  parameter int unsigned CNT_W      = BASE_SHIFT + SHIFT_STEP * ((1 << SEL_W) - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt_q,
  output logic             term,
  output logic             timeout,
  output logic             rst_req
);
  localparam int unsigned NSEL = 1 << SEL_W;

  logic [NSEL-1:0] hit;

  // One terminal comparator per selectable period; >= keeps a shortened
  // period from running past its end
  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    localparam int unsigned SH = wdt_pkg::period_shift(BASE_SHIFT, SHIFT_STEP, g);
    localparam logic [CNT_W-1:0] LAST = CNT_W'((64'd1 << SH) - 64'd1);
    assign hit[g] = (cnt_q >= LAST);
  end

  assign term    = hit[sel];
  assign timeout = en && term && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rst_req <= 1'b0;
    end else if (!en || restart) begin
      cnt_q   <= '0;
      rst_req <= 1'b0;
    end else if (term) begin
      cnt_q   <= '0;
      rst_req <= 1'b1;
    end else begin
      cnt_q   <= cnt_q + CNT_W'(1);
      rst_req <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_service_timer.sv
`timescale 1ns/1ps
module wdt_service_timer #(
  parameter int unsigned       ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR   = ADDR_W'(16'h103A),
  parameter int unsigned       BASE_SHIFT = 15,
  parameter int unsigned       SHIFT_STEP = 2,
  parameter int unsigned       SEL_W      = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [SEL_W-1:0]           period_sel,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [wdt_pkg::BYTE_W-1:0] bus_wdata,
  output logic                       rst_req
);
  localparam int unsigned CNT_W = BASE_SHIFT + SHIFT_STEP * ((1 << SEL_W) - 1);

  wdt_pkg::key_kind_e key;
  logic               armed_q;
  logic               restart;
  logic               term;
  logic               timeout;
  logic [CNT_W-1:0]   cnt_q;

  wdt_bus_decode #(.ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR)) u_decode (
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .key       (key)
  );

  wdt_arm_ctrl u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .key     (key),
    .timeout (timeout),
    .armed_q (armed_q),
    .restart (restart)
  );

  wdt_timebase #(
    .BASE_SHIFT (BASE_SHIFT),
    .SHIFT_STEP (SHIFT_STEP),
    .SEL_W      (SEL_W),
    .CNT_W      (CNT_W)
  ) u_time (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .sel     (period_sel),
    .restart (restart),
    .cnt_q   (cnt_q),
    .term    (term),
    .timeout (timeout),
    .rst_req (rst_req)
  );
endmodule

// File: rtl/wdt_checker.sv
`timescale 1ns/1ps
module wdt_checker #(
  parameter int unsigned CNT_W = 21
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               rst_req,
  input logic [CNT_W-1:0]   cnt,
  input logic               armed,
  input logic               restart,
  input logic               term,
  input wdt_pkg::key_kind_e key
);
  import wdt_pkg::*;

  // High once a full cycle out of reset has passed, so $past is valid
  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    live && rst_req |=> !rst_req);

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    live && en && !restart && !term |=> cnt == $past(cnt) + CNT_W'(1));

  a_r3_arm_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    live && en && key == KEY_ARM_HIT && !term |=> armed && cnt == $past(cnt) + CNT_W'(1));

  a_r4_restart_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    live && restart |=> cnt == '0 && !rst_req);

  a_r6_unarmed_clear_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    live && en && key == KEY_CLEAR_HIT && !armed && !term |=> cnt == $past(cnt) + CNT_W'(1));

  a_r7_arm_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    live && restart |=> !armed);

  a_r8_timeout_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> cnt == '0 && !armed);

  a_r9_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    live && !en |=> cnt == '0 && !rst_req && !armed);

  a_r10_restart_wins: assert property (@(posedge clk) disable iff (!rst_n)
    live && restart && term |=> !rst_req);
endmodule

bind wdt_service_timer wdt_checker #(.CNT_W(CNT_W)) u_wdt_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .rst_req (rst_req),
  .cnt     (cnt_q),
  .armed   (armed_q),
  .restart (restart),
  .term    (term),
  .key     (key)
);

// File: tb/test_wdt_service_timer.sv
`timescale 1ns/1ps
module test_wdt_service_timer;
  localparam int BASE = 4;
  localparam int STEP = 2;
  localparam logic [15:0] SVC   = 16'h103A;
  localparam logic [7:0]  K_ARM = 8'h55;
  localparam logic [7:0]  K_CLR = 8'hAA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic        we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rst_req;

  int cyc = 0;
  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_service_timer #(.BASE_SHIFT(BASE), .SHIFT_STEP(STEP)) i_wdt_service_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .period_sel (sel),
    .bus_we     (we),
    .bus_addr   (addr),
    .bus_wdata  (wdata),
    .rst_req    (rst_req)
  );

  function automatic int lim(int s);
    return 1 << (BASE + STEP * s);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic [1:0] s, output int t0);
    rst_n = 1'b0; en = 1'b1; sel = s; we = 1'b0; addr = '0; wdata = '0;
    step(3);
    rst_n = 1'b1;
    t0 = cyc;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, output int at);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    at = cyc;
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic wait_rise(output int at);
    at = -1;
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk); #1;
      if (rst_req) begin
        at = cyc;
        break;
      end
    end
  endtask

  task automatic t_reset_and_period;
    int t0, r1, r2;
    rst_n = 1'b0; en = 1'b1; sel = 2'd0;
    step(2);
    check(rst_req == 1'b0, "R1 rst_req low in reset", int'(rst_req), 0);
    do_reset(2'd0, t0);
    check(rst_req == 1'b0, "R1 rst_req low after reset", int'(rst_req), 0);
    wait_rise(r1);
    check(r1 == t0 + lim(0), "R1 first timeout edge", r1 - t0, lim(0));
    step(1);
    check(rst_req == 1'b0, "R2 pulse is one cycle", int'(rst_req), 0);
    wait_rise(r2);
    check(r2 == r1 + lim(0), "R8 periodic timeout", r2 - r1, lim(0));
  endtask

  task automatic t_all_periods;
    int t0, r;
    for (int s = 0; s < 4; s++) begin
      do_reset(2'(s), t0);
      wait_rise(r);
      check(r == t0 + lim(s), $sformatf("R2 period for select %0d", s), r - t0, lim(s));
    end
  endtask

  task automatic t_arm_only;
    int t0, w, r;
    do_reset(2'd1, t0);
    bus_write(SVC, K_ARM, w);
    wait_rise(r);
    check(r == t0 + lim(1), "R3 arm alone keeps timeout", r - t0, lim(1));
  endtask

  task automatic t_service_with_gap;
    int t0, w, k, r;
    do_reset(2'd1, t0);
    step(5);
    bus_write(SVC, K_ARM, w);
    step(3);
    bus_write(SVC, 8'h12, w);
    bus_write(16'h2000, 8'h77, w);
    bus_write(SVC, 8'h00, w);
    step(6);
    bus_write(SVC, K_CLR, k);
    wait_rise(r);
    check(r == k + lim(1), "R4 R5 restart after gap", r - k, lim(1));
  endtask

  task automatic t_clear_unarmed;
    int t0, w, r;
    do_reset(2'd1, t0);
    step(4);
    bus_write(SVC, K_CLR, w);
    wait_rise(r);
    check(r == t0 + lim(1), "R6 unarmed clear ignored", r - t0, lim(1));
  endtask

  task automatic t_arm_consumed;
    int t0, w, k1, k2, r;
    do_reset(2'd1, t0);
    bus_write(SVC, K_ARM, w);
    step(10);
    bus_write(SVC, K_CLR, k1);
    step(20);
    bus_write(SVC, K_CLR, k2);
    wait_rise(r);
    check(r == k1 + lim(1), "R7 second clear ignored", r - k1, lim(1));
  endtask

  task automatic t_timeout_drops_arm;
    int t0, w, k, r1, r2;
    do_reset(2'd1, t0);
    bus_write(SVC, K_ARM, w);
    wait_rise(r1);
    check(r1 == t0 + lim(1), "R8 timeout with arm held", r1 - t0, lim(1));
    bus_write(SVC, K_CLR, k);
    wait_rise(r2);
    check(r2 == r1 + lim(1), "R8 arm lost at timeout", r2 - r1, lim(1));
  endtask

  task automatic t_disable;
    int t0, w, j, r, seen;
    do_reset(2'd1, t0);
    bus_write(SVC, K_ARM, w);
    en = 1'b0;
    seen = 0;
    for (int i = 0; i < 150; i++) begin
      step(1);
      if (rst_req) seen++;
    end
    check(seen == 0, "R9 no pulse while disabled", seen, 0);
    en = 1'b1;
    j = cyc;
    step(3);
    bus_write(SVC, K_CLR, w);
    wait_rise(r);
    check(r == j + lim(1), "R9 restart from zero and arm cleared", r - j, lim(1));
  endtask

  task automatic t_restart_on_terminal;
    int t0, w, k, r;
    do_reset(2'd1, t0);
    bus_write(SVC, K_ARM, w);
    while (cyc < t0 + lim(1) - 1) step(1);
    bus_write(SVC, K_CLR, k);
    check(k == t0 + lim(1), "R10 write lands on terminal edge", k - t0, lim(1));
    check(rst_req == 1'b0, "R10 no pulse on restart edge", int'(rst_req), 0);
    wait_rise(r);
    check(r == k + lim(1), "R10 count restarted", r - k, lim(1));
  endtask

  task automatic t_other_address;
    int t0, w, r;
    do_reset(2'd1, t0);
    bus_write(16'h103B, K_ARM, w);
    bus_write(SVC, K_CLR, w);
    bus_write(SVC, K_ARM, w);
    bus_write(16'h003A, K_CLR, w);
    wait_rise(r);
    check(r == t0 + lim(1), "R11 other address ignored", r - t0, lim(1));
  endtask

  initial begin
    #(8 * 150000);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    t_reset_and_period();
    t_all_periods();
    t_arm_only();
    t_service_with_gap();
    t_clear_unarmed();
    t_arm_consumed();
    t_timeout_drops_arm();
    t_disable();
    t_restart_on_terminal();
    t_other_address();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule